// File: doc/BRIEF.md
# Vectored Interrupt Priority Threshold Controller

This block gathers interrupt requests that arrive as vector numbers, one strobe at a time, and keeps them in a pending set with one bit per vector. It hands them to a processor one at a time over a request line and a vector output. A software-written priority threshold decides which pending vectors may be handed over. The processor acknowledges the presented vector, and that vector's pending bit is then cleared.

The upper bits of a vector number form its priority class. A vector may be delivered only while its class is strictly above the threshold. A masked vector stays pending for as long as it takes and is never lost. A second request for a vector that is already pending merges into the existing one. Among the eligible vectors the highest number wins. Once a vector is presented it is held until the processor acknowledges it. The only exception is a raised threshold that masks it, which withdraws it.

Top module: `irq_thresh_ctrl`

## Requirements
- R1: After reset, no vector is pending, the threshold is 0, `irq_o` is low and `vec_o` is 0.
- R2: A request strobe sets the pending bit of `req_vec_i` at that clock edge. With nothing presented, the vector is presented at the next edge, so `irq_o` rises two edges after the strobe is driven.
- R3: A request for a vector that is already pending merges with it, and the vector is delivered only once.
- R4: The class of a vector is bits 7:4 of the vector number. A vector is eligible only when its class is strictly greater than the threshold, so a class equal to the threshold is held back.
- R5: With threshold 0, class 0 vectors are never delivered. With threshold 15, no vector is delivered.
- R6: A threshold write is registered at the edge where `thr_we_i` is high and applies to selection in the following cycle. A held vector that becomes eligible is then presented at the next edge.
- R7: When no vector is presented, the highest-numbered eligible pending vector is the one loaded.
- R8: A presented vector stays on `vec_o`, with `irq_o` high, until it is acknowledged, even when higher vectors arrive.
- R9: `ack_i` while `irq_o` is high clears the presented vector's pending bit and drops `irq_o` for at least one cycle. `ack_i` while `irq_o` is low has no effect. A request for the same vector in the acknowledge cycle leaves the bit set, and the vector is delivered again.
- R10: If the threshold is raised to or above the presented vector's class, `irq_o` drops in the cycle after the write. The vector stays pending and is delivered once the threshold falls below its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_v_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Vector number being requested |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_i | input | 4 | New threshold value |
| ack_i | input | 1 | Processor acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Presented vector number |

## Verification
The bench builds the block with its default parameters: 8-bit vectors and a 4-bit class, which gives 256 pending bits and 16 classes. With this build it can reach both threshold extremes, 0 and 15. It can also check the equal-class boundary, merging of duplicate requests, and re-requests that coincide with an acknowledge. Delivery order is checked against a queue of expected vectors, including a case where a lower vector is already presented when higher ones arrive.

// File: rtl/irq_thresh_ctrl.sv
module irq_thresh_ctrl #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_v_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             thr_we_i,
  input  logic [CLS_W-1:0] thr_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int NVEC = 1 << VEC_W;

  logic [NVEC-1:0]  pend_q, pend_d;
  logic [CLS_W-1:0] thr_q;
  logic             pres_v;
  logic [VEC_W-1:0] pres_vec;
  logic             found;
  logic [VEC_W-1:0] sel;
  logic             held_ok, ack_fire;

  // highest eligible vector: later (higher) hits overwrite earlier ones
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NVEC; i++) begin
      if (pend_q[i] && (VEC_W'(i) >> (VEC_W - CLS_W)) > VEC_W'(thr_q)) begin
        found = 1'b1;
        sel   = VEC_W'(i);
      end
    end
  end

  assign held_ok  = pres_vec[VEC_W-1 -: CLS_W] > thr_q;
  assign irq_o    = pres_v & held_ok;
  assign vec_o    = pres_vec;
  assign ack_fire = ack_i & irq_o;

  always_comb begin
    pend_d = pend_q;
    if (ack_fire) pend_d[pres_vec] = 1'b0;
    if (req_v_i)  pend_d[req_vec_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      thr_q    <= '0;
      pres_v   <= 1'b0;
      pres_vec <= '0;
    end else begin
      pend_q <= pend_d;
      if (thr_we_i) thr_q <= thr_i;
      if (ack_fire || (pres_v && !held_ok)) begin
        pres_v <= 1'b0;
      end else if (!pres_v && found) begin
        pres_v   <= 1'b1;
        pres_vec <= sel;
      end
    end
  end

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_v_i |=> pend_q[$past(req_vec_i)]);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_i && !thr_we_i) |=> (irq_o && $stable(vec_o)));

  assert_presented_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend_q[vec_o]);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !(req_v_i && req_vec_i == vec_o)) |=> !pend_q[$past(vec_o)]);

  assert_ack_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !irq_o);

endmodule

// File: tb/irq_thresh_ctrl_tb.sv
module irq_thresh_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_v_i = 1'b0;
  logic [7:0] req_vec_i = '0;
  logic       thr_we_i = 1'b0;
  logic [3:0] thr_i = '0;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [7:0] vec_o;

  int errors = 0;
  int checks = 0;
  logic       auto_ack = 1'b0;
  logic       force_ack = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  irq_thresh_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_v_i(req_v_i), .req_vec_i(req_vec_i),
    .thr_we_i(thr_we_i), .thr_i(thr_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v);
    req_v_i = 1'b1; req_vec_i = v;
    @(negedge clk);
    req_v_i = 1'b0;
  endtask

  task automatic set_thr(input logic [3:0] t);
    thr_we_i = 1'b1; thr_i = t;
    @(negedge clk);
    thr_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops the expected vector for each delivery and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (auto_ack && irq_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected delivery", vec_o, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(vec_o == e, "R7 delivery order", vec_o, e);
        end
        ack_i = 1'b1;
      end else begin
        ack_i = force_ack;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    check(vec_o == 8'h00, "R1 vec after reset", vec_o, 0);

    // R2 latency, R8 hold, R3 merge
    send(8'h35);
    check(irq_o == 1'b0, "R2 one edge after strobe", irq_o, 0);
    send(8'h92);
    check(irq_o == 1'b1 && vec_o == 8'h35, "R2 presented two edges after strobe", vec_o, 8'h35);
    send(8'h92);
    send(8'h47);
    check(irq_o == 1'b1 && vec_o == 8'h35, "R8 held despite higher arrivals", vec_o, 8'h35);
    exp_q.push_back(8'h35); exp_q.push_back(8'h92); exp_q.push_back(8'h47);
    auto_ack = 1'b1; idle(12); auto_ack = 1'b0; idle(1);
    check(exp_q.size() == 0, "R3 all expected delivered once", exp_q.size(), 0);
    check(irq_o == 1'b0, "R3 no second delivery of merged vector", irq_o, 0);

    // R4 equal class blocked, R5 class 0 at threshold 0
    set_thr(4'd5);
    send(8'h50); send(8'h0A); send(8'h61);
    exp_q.push_back(8'h61);
    auto_ack = 1'b1; idle(10); auto_ack = 1'b0; idle(1);
    check(exp_q.size() == 0, "R4 class above threshold delivered", exp_q.size(), 0);
    check(irq_o == 1'b0, "R4 class equal to threshold held", irq_o, 0);
    set_thr(4'd0);
    exp_q.push_back(8'h50);
    auto_ack = 1'b1; idle(10); auto_ack = 1'b0; idle(1);
    check(exp_q.size() == 0, "R4 held vector released", exp_q.size(), 0);
    check(irq_o == 1'b0, "R5 class 0 blocked at threshold 0", irq_o, 0);

    // R5 threshold 15, R9 ack ignored while low, R6 latency
    set_thr(4'hF);
    send(8'hF3);
    force_ack = 1'b1; idle(4); force_ack = 1'b0; idle(1);
    check(irq_o == 1'b0, "R5 threshold 15 blocks class 15", irq_o, 0);
    set_thr(4'hE);
    check(irq_o == 1'b0, "R6 selection cycle after write", irq_o, 0);
    @(negedge clk);
    check(irq_o == 1'b1 && vec_o == 8'hF3, "R6 delivered after lowering, ack while low ignored (R9)", vec_o, 8'hF3);

    // R9 same-vector request during acknowledge
    force_ack = 1'b1;
    send(8'hF3);
    force_ack = 1'b0;
    check(irq_o == 1'b0, "R9 irq drops after ack", irq_o, 0);
    @(negedge clk);
    check(irq_o == 1'b1 && vec_o == 8'hF3, "R9 re-request during ack redelivered", vec_o, 8'hF3);
    force_ack = 1'b1; idle(1); force_ack = 1'b0; idle(3);
    check(irq_o == 1'b0, "R9 bit cleared by ack", irq_o, 0);

    // R10 withdrawal and retention
    set_thr(4'd0);
    send(8'h84);
    @(negedge clk);
    check(irq_o == 1'b1 && vec_o == 8'h84, "R10 setup presented", vec_o, 8'h84);
    set_thr(4'd9);
    check(irq_o == 1'b0, "R10 withdrawn after threshold raise", irq_o, 1'b0);
    idle(3);
    check(irq_o == 1'b0, "R10 stays withdrawn", irq_o, 0);
    set_thr(4'd3);
    @(negedge clk);
    check(irq_o == 1'b1 && vec_o == 8'h84, "R10 retained vector delivered", vec_o, 8'h84);
    force_ack = 1'b1; idle(1); force_ack = 1'b0; idle(1);
    check(irq_o == 1'b0, "R10 cleared after ack", irq_o, 0);

    // R7 highest first when several become eligible together
    set_thr(4'hF);
    send(8'h21); send(8'hA8); send(8'h7F);
    set_thr(4'd0);
    exp_q.push_back(8'hA8); exp_q.push_back(8'h7F); exp_q.push_back(8'h21);
    auto_ack = 1'b1; idle(12); auto_ack = 1'b0; idle(1);
    check(exp_q.size() == 0, "R7 all delivered", exp_q.size(), 0);
    check(irq_o == 1'b0, "R7 idle afterwards", irq_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule